// File: doc/BRIEF.md
# Two-Way Page Descriptor Cache

This block holds recently used page descriptors for a paged virtual-memory translator. The address space has four sections, chosen by the top two bits of the virtual address. Each section has eight sets, and each set has two ways, a left way and a right way. A lookup presents a virtual address. The block picks a set from scattered address bits, compares a 16-bit tag against both ways, and reports on the same cycle whether either way matched. It also reports which way matched, the page descriptor rebuilt from the stored entry, the owning segment's access byte and the segment's cacheable flag.

A fill presents a virtual address, a page descriptor and the first word of the owning segment descriptor. The entry is written on the next rising clock edge, but only if fault capture is enabled and the page descriptor is marked present. An empty way is used first. When both ways of the set are occupied, a single "last updated" flag, kept in the left entry of the set, names the way to keep, and the other way is overwritten. Walking the page tables and checking permissions are done by the surrounding translator.

Top module: `pdc_cache`

## Requirements
- R1: The set is chosen by the address bits {va[31:30], va[17], va[12:11]}, where va[31:30] is the section. Addresses that differ only in va[10:0] share an entry. Addresses that differ in any index bit never see each other's entries.
- R2: The stored tag is {va[29:18], va[16:13]}. A lookup hits a way only if that way is valid and its tag equals the tag of the lookup address.
- R3: A fill is written only when fill_en_i is 1, fill_capture_i is 1 and fill_pd_i[0] (present) is 1. Any other fill changes nothing that a lookup can see.
- R4: On a hit, lk_pd_o equals (fill_pd_i & 32'hFFFFF836) | 1. lk_acc_o equals fill_sd0_i[31:24], and lk_cache_o equals fill_sd0_i[3], all taken from the fill that wrote the way that hit.
- R5: A fill goes to the left way (lk_way_o = 0) if the left way is invalid. Otherwise it goes to the right way (lk_way_o = 1) if the right way is invalid.
- R6: If both ways are valid, the fill replaces the way that was not the most recently written. Every fill then marks its own way as the most recently written in that set.
- R7: If both ways match, the left way is reported. On a miss, lk_way_o, lk_pd_o, lk_acc_o and lk_cache_o are all 0.
- R8: After reset every entry is invalid, so every lookup misses.
- R9: A lookup is combinational from the stored state. A fill becomes visible to lookups from the first rising edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup matched a valid way |
| lk_way_o | output | 1 | Matching way: 0 left, 1 right |
| lk_pd_o | output | 32 | Rebuilt page descriptor |
| lk_acc_o | output | 8 | Access byte of the owning segment |
| lk_cache_o | output | 1 | Cacheable flag of the owning segment |
| fill_en_i | input | 1 | Fill request |
| fill_capture_i | input | 1 | Fault capture enabled; fills are ignored while it is 0 |
| fill_va_i | input | 32 | Fill virtual address |
| fill_pd_i | input | 32 | Page descriptor to store |
| fill_sd0_i | input | 32 | Segment descriptor word 0 |

## Verification
The random part draws its addresses from a small pool of sections, sets and tags. This forces many collisions in the same set, so every path through the replacement choice is taken many times. Those lookups are compared with a bench model of ways, tags and the last-updated flag. Directed cases separate behaviours that random traffic seldom isolates:
- a fill that is rejected for missing capture, and one rejected for a missing present bit;
- an empty-left fill, an empty-right fill and a replacement after each flag state;
- addresses that differ only in the page offset (must share an entry), only in the section bit or only in one tag bit (must not);
- a set holding the same tag in both ways, which must report the left way.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  parameter int unsigned SECTIONS = 4;
  parameter int unsigned SETS_PER_SEC = 8;
  parameter int unsigned TAG_W = 16;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned ACC_W = 8;
  localparam int unsigned ENTRIES = SECTIONS * SETS_PER_SEC;
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [WORD_W-1:0] PD_KEEP = 32'hFFFF_F836;
  localparam int unsigned USED_BIT = 6;
  localparam int unsigned CACHE_BIT = 3;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [TAG_W-1:0] tag_t;

  function automatic idx_t set_of(input logic [WORD_W-1:0] va);
    return {va[31:30], va[17], va[12:11]};
  endfunction

  function automatic tag_t tag_of(input logic [WORD_W-1:0] va);
    return {va[29:18], va[16:13]};
  endfunction
endpackage

// File: rtl/pdc_way_store.sv
module pdc_way_store
  import pdc_pkg::*;
#(
  parameter bit HAS_USED = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  idx_t              wr_idx_i,
  input  logic [WORD_W-1:0] wr_low_i,
  input  logic [WORD_W-1:0] wr_high_i,
  input  logic              used_en_i,
  input  logic              used_val_i,
  input  idx_t              lk_idx_i,
  output logic [WORD_W-1:0] lk_low_o,
  output logic [WORD_W-1:0] lk_high_o,
  output logic [WORD_W-1:0] fl_high_o
);
  logic [WORD_W-1:0] low_q  [ENTRIES];
  logic [WORD_W-1:0] high_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        low_q[i]  <= '0;
        high_q[i] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        low_q[wr_idx_i]  <= wr_low_i;
        high_q[wr_idx_i] <= wr_high_i;
      end
      // used flag overrides bit 6 of the left word after any write
      if (HAS_USED && used_en_i) high_q[wr_idx_i][USED_BIT] <= used_val_i;
    end
  end

  assign lk_low_o  = low_q[lk_idx_i];
  assign lk_high_o = high_q[lk_idx_i];
  assign fl_high_o = high_q[wr_idx_i];
endmodule

// File: rtl/pdc_tag_cmp.sv
module pdc_tag_cmp
  import pdc_pkg::*;
(
  input  logic [WORD_W-1:0] low_i,
  input  logic [WORD_W-1:0] high_i,
  input  tag_t              tag_i,
  output logic              hit_o
);
  assign hit_o = high_i[0] && (low_i[TAG_W-1:0] == tag_i);
endmodule

// File: rtl/pdc_victim.sv
module pdc_victim (
  input  logic good_l_i,
  input  logic good_r_i,
  input  logic last_r_i,
  output logic way_o
);
  always_comb begin
    if (!good_l_i)      way_o = 1'b0;
    else if (!good_r_i) way_o = 1'b1;
    else                way_o = ~last_r_i;
  end
endmodule

// File: rtl/pdc_cache.sv
module pdc_cache
  import pdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] lk_va_i,
  output logic              lk_hit_o,
  output logic              lk_way_o,
  output logic [WORD_W-1:0] lk_pd_o,
  output logic [ACC_W-1:0]  lk_acc_o,
  output logic              lk_cache_o,
  input  logic              fill_en_i,
  input  logic              fill_capture_i,
  input  logic [WORD_W-1:0] fill_va_i,
  input  logic [WORD_W-1:0] fill_pd_i,
  input  logic [WORD_W-1:0] fill_sd0_i
);
  logic [1:0][WORD_W-1:0] lk_low, lk_high, fl_high;
  logic [1:0]             way_hit, wr_en;
  logic                   fill_ok, victim, sel;
  idx_t                   lk_idx, fl_idx;
  tag_t                   lk_tag;
  logic [WORD_W-1:0]      new_low, new_high;

  assign lk_idx  = set_of(lk_va_i);
  assign lk_tag  = tag_of(lk_va_i);
  assign fl_idx  = set_of(fill_va_i);
  assign fill_ok = fill_en_i && fill_capture_i && fill_pd_i[0];

  assign new_low = {fill_sd0_i[WORD_W-1 -: ACC_W], {(WORD_W-ACC_W-TAG_W){1'b0}}, tag_of(fill_va_i)};
  always_comb begin
    new_high = fill_pd_i & PD_KEEP;
    new_high[CACHE_BIT] = fill_sd0_i[CACHE_BIT];
    new_high[0] = 1'b1;
  end

  pdc_victim u_victim (
    .good_l_i (fl_high[0][0]),
    .good_r_i (fl_high[1][0]),
    .last_r_i (fl_high[0][USED_BIT]),
    .way_o    (victim)
  );

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign wr_en[w] = fill_ok && (victim == w[0]);

    pdc_way_store #(.HAS_USED(w == 0)) u_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en[w]),
      .wr_idx_i   (fl_idx),
      .wr_low_i   (new_low),
      .wr_high_i  (new_high),
      .used_en_i  (fill_ok),
      .used_val_i (victim),
      .lk_idx_i   (lk_idx),
      .lk_low_o   (lk_low[w]),
      .lk_high_o  (lk_high[w]),
      .fl_high_o  (fl_high[w])
    );

    pdc_tag_cmp u_cmp (
      .low_i  (lk_low[w]),
      .high_i (lk_high[w]),
      .tag_i  (lk_tag),
      .hit_o  (way_hit[w])
    );
  end

  assign sel      = ~way_hit[0];
  assign lk_hit_o = |way_hit;
  assign lk_way_o = lk_hit_o && sel;

  always_comb begin
    lk_pd_o    = '0;
    lk_acc_o   = '0;
    lk_cache_o = 1'b0;
    if (lk_hit_o) begin
      lk_pd_o    = (lk_high[sel] & PD_KEEP) | {{(WORD_W-1){1'b0}}, 1'b1};
      lk_acc_o   = lk_low[sel][WORD_W-1 -: ACC_W];
      lk_cache_o = lk_high[sel][CACHE_BIT];
    end
  end
endmodule

// File: rtl/pdc_cache_chk.sv
module pdc_cache_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] lk_va_i,
  input logic        lk_hit_o,
  input logic        lk_way_o,
  input logic [31:0] lk_pd_o,
  input logic [7:0]  lk_acc_o,
  input logic        lk_cache_o,
  input logic        fill_en_i,
  input logic        fill_capture_i,
  input logic [31:0] fill_va_i,
  input logic [31:0] fill_pd_i
);
  logic fill_ok;
  assign fill_ok = fill_en_i && fill_capture_i && fill_pd_i[0];

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (!lk_way_o && lk_pd_o == 32'h0 && lk_acc_o == 8'h0 && !lk_cache_o));

  p_pd_form_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_pd_o[0] && (lk_pd_o & 32'h0000_07C8) == 32'h0));

  p_reject_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_ok |=> (lk_va_i != $past(lk_va_i)) ||
                 (lk_hit_o == $past(lk_hit_o) && lk_pd_o == $past(lk_pd_o)));

  p_fill_visible_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ok && lk_va_i == fill_va_i && !lk_hit_o) |=> (lk_va_i != $past(lk_va_i)) ||
      (lk_hit_o && lk_pd_o == (($past(fill_pd_i) & 32'hFFFF_F836) | 32'h1)));
endmodule

bind pdc_cache pdc_cache_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lk_va_i        (lk_va_i),
  .lk_hit_o       (lk_hit_o),
  .lk_way_o       (lk_way_o),
  .lk_pd_o        (lk_pd_o),
  .lk_acc_o       (lk_acc_o),
  .lk_cache_o     (lk_cache_o),
  .fill_en_i      (fill_en_i),
  .fill_capture_i (fill_capture_i),
  .fill_va_i      (fill_va_i),
  .fill_pd_i      (fill_pd_i)
);

// File: tb/tb_pdc_cache.sv
`timescale 1ns/1ps
module tb_pdc_cache;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_va_i = '0;
  logic        lk_hit_o, lk_way_o, lk_cache_o;
  logic [31:0] lk_pd_o;
  logic [7:0]  lk_acc_o;
  logic        fill_en_i = 1'b0, fill_capture_i = 1'b0;
  logic [31:0] fill_va_i = '0, fill_pd_i = '0, fill_sd0_i = '0;

  pdc_cache dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model
  bit          m_good [2][32];
  logic [15:0] m_tag  [2][32];
  logic [31:0] m_pd   [2][32];
  logic [7:0]  m_acc  [2][32];
  bit          m_c    [2][32];
  bit          m_last_r [32];

  function automatic logic [31:0] mk_va(input logic [1:0] sec, input logic [2:0] st,
                                        input logic [15:0] tg, input logic [10:0] off);
    return {sec, tg[15:4], st[2], tg[3:0], st[1:0], off};
  endfunction
  function automatic int idx_m(input logic [31:0] va);
    return int'({va[31:30], va[17], va[12:11]});
  endfunction
  function automatic logic [15:0] tag_m(input logic [31:0] va);
    return {va[29:18], va[16:13]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pd, input logic [31:0] sd0,
                      input bit cap);
    int ix, w;
    @(negedge clk_i);
    fill_en_i = 1'b1; fill_capture_i = cap;
    fill_va_i = va; fill_pd_i = pd; fill_sd0_i = sd0;
    @(negedge clk_i);
    fill_en_i = 1'b0;
    if (cap && pd[0]) begin
      ix = idx_m(va);
      if (!m_good[0][ix]) w = 0;
      else if (!m_good[1][ix]) w = 1;
      else w = m_last_r[ix] ? 0 : 1;
      m_good[w][ix] = 1'b1;
      m_tag[w][ix]  = tag_m(va);
      m_pd[w][ix]   = (pd & 32'hFFFF_F836) | 32'h1;
      m_acc[w][ix]  = sd0[31:24];
      m_c[w][ix]    = sd0[3];
      m_last_r[ix]  = (w == 1);
    end
  endtask

  // lookup and compare all outputs against the model
  task automatic look(input logic [31:0] va, input string req);
    int ix;
    bit h0, h1;
    logic [43:0] exp;
    int w;
    @(negedge clk_i);
    lk_va_i = va;
    #2;
    ix = idx_m(va);
    h0 = m_good[0][ix] && m_tag[0][ix] == tag_m(va);
    h1 = m_good[1][ix] && m_tag[1][ix] == tag_m(va);
    w  = h0 ? 0 : 1;
    if (h0 || h1) exp = {1'b1, w[0], m_pd[w][ix], m_acc[w][ix], m_c[w][ix]};
    else exp = '0;
    check(req, {20'h0, lk_hit_o, lk_way_o, lk_pd_o, lk_acc_o, lk_cache_o}, {20'h0, exp});
  endtask

  task automatic look_way(input logic [31:0] va, input bit hit, input bit way, input string req);
    @(negedge clk_i);
    lk_va_i = va;
    #2;
    check(req, {62'h0, lk_hit_o, lk_way_o}, {62'h0, hit, way});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c, d, e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R8 reset: everything misses
    look(mk_va(2'd0, 3'd0, 16'h0000, 11'h0), "R8");
    look(mk_va(2'd3, 3'd7, 16'hFFFF, 11'h7FF), "R8");
    look_way(32'h0, 1'b0, 1'b0, "R8");

    // R3 rejected fills
    a = mk_va(2'd1, 3'd2, 16'h1234, 11'h10);
    fill(a, 32'hABCD_E83F, 32'h5A00_0008, 1'b0);
    look_way(a, 1'b0, 1'b0, "R3 no capture");
    fill(a, 32'hABCD_E83E, 32'h5A00_0008, 1'b1);
    look_way(a, 1'b0, 1'b0, "R3 not present");

    // R9/R4/R5 first fill lands left
    fill(a, 32'hABCD_EFFF, 32'h5A00_0008, 1'b1);
    look_way(a, 1'b1, 1'b0, "R5 left first");
    look(a, "R4 R9 fields");
    check("R4 pd rebuild", {32'h0, lk_pd_o}, {32'h0, 32'hABCD_E837});
    check("R4 acc", {56'h0, lk_acc_o}, {56'h0, 8'h5A});
    check("R4 cacheable", {63'h0, lk_cache_o}, 64'h1);

    // R1 offset bits ignored, section bit separates
    look_way(mk_va(2'd1, 3'd2, 16'h1234, 11'h7EF), 1'b1, 1'b0, "R1 offset shares");
    look_way(mk_va(2'd0, 3'd2, 16'h1234, 11'h10), 1'b0, 1'b0, "R1 section separates");
    look_way(mk_va(2'd1, 3'd6, 16'h1234, 11'h10), 1'b0, 1'b0, "R1 va17 separates");
    // R2 one tag bit separates
    look_way(mk_va(2'd1, 3'd2, 16'h1235, 11'h10), 1'b0, 1'b0, "R2 tag bit13");
    look_way(mk_va(2'd1, 3'd2, 16'h9234, 11'h10), 1'b0, 1'b0, "R2 tag bit29");

    // R5 right when left taken, R6 replacement order
    b = mk_va(2'd1, 3'd2, 16'h0F0F, 11'h0);
    c = mk_va(2'd1, 3'd2, 16'h7777, 11'h0);
    d = mk_va(2'd1, 3'd2, 16'h0001, 11'h0);
    fill(b, 32'h1111_1001, 32'h3300_0000, 1'b1);
    look_way(b, 1'b1, 1'b1, "R5 right second");
    fill(c, 32'h2222_2001, 32'h4400_0000, 1'b1);
    look_way(c, 1'b1, 1'b0, "R6 replace left");
    look_way(a, 1'b0, 1'b0, "R6 evicted");
    look_way(b, 1'b1, 1'b1, "R6 right kept");
    fill(d, 32'h3333_3001, 32'h5500_0008, 1'b1);
    look_way(d, 1'b1, 1'b1, "R6 replace right");
    look_way(b, 1'b0, 1'b0, "R6 evicted right");
    look(c, "R6 left kept");

    // R7 same tag in both ways: left wins
    e = mk_va(2'd2, 3'd5, 16'hBEEF, 11'h0);
    fill(e, 32'h4444_4001, 32'h6600_0000, 1'b1);
    fill(e, 32'h5555_5001, 32'h7700_0000, 1'b1);
    look_way(e, 1'b1, 1'b0, "R7 left priority");
    check("R7 left pd", {32'h0, lk_pd_o}, {32'h0, 32'h4444_4001});

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] va;
      va = mk_va($urandom_range(1, 0), $urandom_range(3, 0),
                 16'h1000 * $urandom_range(3, 0) + 16'h0003 * $urandom_range(2, 0),
                 11'($urandom));
      if ($urandom_range(2, 0) == 0)
        fill(va, $urandom | ($urandom_range(4, 0) != 0 ? 32'h1 : 32'h0), $urandom,
             $urandom_range(4, 0) != 0);
      else
        look(va, "R2 R4 R6 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule